// File: doc/BRIEF.md
# Integer to single-precision float converter

This block turns a signed 64-bit two's-complement integer into an IEEE-754 binary32 value, rounding to nearest with ties to even. It rounds in two steps: first to a 53-bit significand, as a double-precision intermediate would, and then to a 24-bit significand. Rounding twice can move a result away from the correctly rounded value. An integer that lands just past a single-precision midpoint can be pulled onto that midpoint by the first step, and the tie is then broken the wrong way. To stop this, the block conditions the operand before either rounding step. When the operand cannot be held exactly in 53 bits and some of its 11 lowest bits are set, those 11 bits are cleared and bit 11 is set. The conditioned value is then exact in 53 bits and still carries a sticky mark below the single-precision guard bit.

The converter is a two-register pipeline. A caller presents an operand with `in_valid`. The result comes out with `out_valid`, in issue order, together with a flag that reports whether any bits were discarded. The block can accept a new operand on every cycle and has no back-pressure.

Top module: `int2f_conv`

## Requirements
- R1: An operand accepted with `in_valid` on rising edge k produces `out_valid` high after rising edge k+1. Every rising edge without `in_valid` gives `out_valid` low two edges later. One operand can be accepted on every edge.
- R2: For every operand, `out_float` equals the single round-to-nearest-even rounding of the integer to a 24-bit significand. The layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0.
- R3: An exact midpoint between two adjacent single values goes to the neighbour whose significand LSB is zero. 2^60 + 2^36 gives 0x5D800000, which is 2^60. 2^60 + 3·2^36 gives 0x5D800002, which is 2^60 + 2^38.
- R4: Operands just off a midpoint are not captured by the intermediate rounding. Every integer in [2^60 + 2^36 + 1, 2^60 + 2^36 + 2^7] gives 0x5D800001, which is 2^60 + 2^37. 2^60 + 3·2^36 − 1 also gives 0x5D800001.
- R5: A negative operand gives the conversion of its magnitude with bit 31 set. The inexact flag is the same as for the magnitude.
- R6: Operand zero gives 0x00000000, which is +0.0, with the inexact flag clear.
- R7: Operand −2^63 gives exactly 0xDF000000. That value has sign 1, exponent field 190, zero fraction and inexact clear.
- R8: The exponent field is 127 plus the index of the leading one of the magnitude. A round-up that overflows the significand adds one to the exponent and leaves a zero fraction. For example, 2^25 − 1 gives 0x4C000000.
- R9: An operand whose magnitude is below 2^24 converts with `out_inexact` clear. For any other operand, `out_inexact` is set exactly when a discarded bit of the magnitude is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_int | input | 64 | Signed two's-complement operand |
| out_valid | output | 1 | Result strobe |
| out_float | output | 32 | binary32 result |
| out_inexact | output | 1 | Set when the result differs from the operand |

## Verification
A result is due two rising edges after the operand is driven: the edge that accepts the operand fills the first register, and the next edge fills the output register. The bench drives operands on falling edges, so each expectation is queued one half-cycle before the accepting edge. It reads the outputs on later falling edges and pops one expectation for each `out_valid`, so the in-order, fixed-latency behaviour of R1 is checked directly. A strobe with nothing queued, or a queue still holding items at the end, counts as a failure. Midpoint, near-midpoint, carry and extreme operands have hand-computed expectations. Random and midpoint-targeted operands are checked against a reference that rounds the magnitude to 24 bits in a single step.

// File: rtl/int2f_pkg.sv
package int2f_pkg;
    // Default geometry of the conversion
    localparam int INT_W    = 64;   // integer operand width
    localparam int MID_SIG  = 53;   // intermediate significand width
    localparam int SGL_SIG  = 24;   // final significand width, hidden bit included
    localparam int SGL_EXP  = 8;    // final exponent field width
    localparam int SGL_BIAS = 127;  // final exponent bias
endpackage

// File: rtl/int2f_precond.sv
// Sticky conditioning: when the operand is not exact in KEEP bits and its
// low (W-KEEP) bits are not all zero, replace them with a single sticky one
// one place above them.
module int2f_precond #(
    parameter int W    = 64,
    parameter int KEEP = 53
) (
    input  logic [W-1:0] op_i,
    output logic [W-1:0] op_o
);
    localparam int LOWB = W - KEEP;

    logic [W-1:0] hi_inc;
    logic         wide;
    logic         low_nz;

    always_comb begin
        hi_inc = $unsigned($signed(op_i) >>> KEEP) + W'(1);
        wide   = hi_inc > W'(1);
        low_nz = |op_i[LOWB-1:0];
        op_o   = op_i;
        if (wide && low_nz) begin
            op_o = {op_i[W-1:LOWB+1], 1'b1, {LOWB{1'b0}}};
        end
    end
endmodule

// File: rtl/int2f_norm.sv
// Leading-one search and left justification of an unsigned magnitude.
module int2f_norm #(
    parameter int W  = 64,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  mag_i,
    output logic [W-1:0]  norm_o,
    output logic [PW-1:0] lead_o
);
    always_comb begin
        lead_o = '0;
        for (int i = 0; i < W; i++) begin
            if (mag_i[i]) lead_o = PW'(i);
        end
        norm_o = mag_i << (PW'(W - 1) - lead_o);
    end
endmodule

// File: rtl/int2f_round.sv
// Round-to-nearest-even of a left-justified fraction to KEEP bits.
module int2f_round #(
    parameter int W    = 64,
    parameter int KEEP = 24,
    parameter int EW   = 7
) (
    input  logic [W-1:0]    frac_i,
    input  logic [EW-1:0]   exp_i,
    output logic [KEEP-1:0] sig_o,
    output logic [EW-1:0]   exp_o,
    output logic            inexact_o
);
    localparam int DROP = W - KEEP;

    logic            guard;
    logic            sticky;
    logic            bump;
    logic [KEEP:0]   sum;

    always_comb begin
        guard     = frac_i[DROP-1];
        sticky    = |frac_i[DROP-2:0];
        bump      = guard & (sticky | frac_i[DROP]);
        sum       = {1'b0, frac_i[W-1:DROP]} + (KEEP+1)'(bump);
        inexact_o = guard | sticky;
        if (sum[KEEP]) begin
            sig_o = {1'b1, {(KEEP-1){1'b0}}};
            exp_o = exp_i + EW'(1);
        end else begin
            sig_o = sum[KEEP-1:0];
            exp_o = exp_i;
        end
    end
endmodule

// File: rtl/int2f_conv.sv
module int2f_conv
    import int2f_pkg::*;
#(
    parameter int W     = INT_W,
    parameter int MIDS  = MID_SIG,
    parameter int SIGS  = SGL_SIG,
    parameter int EXPW  = SGL_EXP,
    parameter int BIAS  = SGL_BIAS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_int,
    output logic                 out_valid,
    output logic [EXPW+SIGS-1:0] out_float,
    output logic                 out_inexact
);
    localparam int PW   = $clog2(W);
    localparam int POSW = PW + 1;
    localparam int FW   = EXPW + SIGS;
    localparam int MIDD = W - MIDS;

    typedef struct packed {
        logic            a_valid;
        logic            a_sign;
        logic [POSW-1:0] a_pos;
        logic [W-1:0]    a_norm;
        logic            b_valid;
        logic [FW-1:0]   b_res;
        logic            b_inexact;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [W-1:0]    cond_op;
    logic [W-1:0]    mag;
    logic [W-1:0]    norm;
    logic [PW-1:0]   lead;
    logic [MIDS-1:0] mid_sig;
    logic [POSW-1:0] mid_pos;
    logic            mid_inexact;
    logic [SIGS-1:0] fin_sig;
    logic [POSW-1:0] fin_pos;
    logic            fin_inexact;

    int2f_precond #(.W(W), .KEEP(MIDS)) u_precond (
        .op_i (in_int),
        .op_o (cond_op)
    );

    assign mag = cond_op[W-1] ? (~cond_op + W'(1)) : cond_op;

    int2f_norm #(.W(W), .PW(PW)) u_norm (
        .mag_i  (mag),
        .norm_o (norm),
        .lead_o (lead)
    );

    int2f_round #(.W(W), .KEEP(MIDS), .EW(POSW)) u_round_mid (
        .frac_i    (pipe_q.a_norm),
        .exp_i     (pipe_q.a_pos),
        .sig_o     (mid_sig),
        .exp_o     (mid_pos),
        .inexact_o (mid_inexact)
    );

    int2f_round #(.W(W), .KEEP(SIGS), .EW(POSW)) u_round_fin (
        .frac_i    ({mid_sig, {MIDD{1'b0}}}),
        .exp_i     (mid_pos),
        .sig_o     (fin_sig),
        .exp_o     (fin_pos),
        .inexact_o (fin_inexact)
    );

    always_comb begin
        pipe_d         = pipe_q;
        // stage A: condition, take magnitude, justify
        pipe_d.a_valid = in_valid;
        pipe_d.a_sign  = cond_op[W-1];
        pipe_d.a_pos   = {1'b0, lead};
        pipe_d.a_norm  = norm;
        // stage B: two rounding steps and packing
        pipe_d.b_valid = pipe_q.a_valid;
        if (fin_sig[SIGS-1]) begin
            pipe_d.b_res     = {pipe_q.a_sign,
                                EXPW'(BIAS) + EXPW'(fin_pos),
                                fin_sig[SIGS-2:0]};
            pipe_d.b_inexact = mid_inexact | fin_inexact;
        end else begin
            pipe_d.b_res     = '0;
            pipe_d.b_inexact = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid   = pipe_q.b_valid;
    assign out_float   = pipe_q.b_res;
    assign out_inexact = pipe_q.b_inexact;
endmodule

// File: rtl/int2f_conv_chk.sv
module int2f_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_int,
    input logic        out_valid,
    input logic [31:0] out_float,
    input logic        out_inexact
);
    // R1: fixed two-edge latency, no spurious strobe
    p_valid_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R5: sign bit follows the operand sign for nonzero operands
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_int != 64'd0) |=> ##1 (out_float[31] == $past(in_int[63], 2)));

    // R6: zero converts to +0.0, exact
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_int == 64'd0) |=> ##1 (out_float == 32'd0 && !out_inexact));

    // R7: most negative operand
    p_min_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_int == 64'h8000_0000_0000_0000)
        |=> ##1 (out_float == 32'hDF00_0000 && !out_inexact));

    // R8: exponent field of a nonzero result stays within 127..190
    p_exp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_float != 32'd0)
        |-> (out_float[30:23] >= 8'd127 && out_float[30:23] <= 8'd190));

    // R9: small magnitudes are exact
    p_small_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $signed(in_int) < 64'sd16777216 && $signed(in_int) > -64'sd16777216)
        |=> ##1 !out_inexact);
    p_low_exp_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_float[30:23] < 8'd151) |-> !out_inexact);
endmodule

bind int2f_conv int2f_conv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_int      (in_int),
    .out_valid   (out_valid),
    .out_float   (out_float),
    .out_inexact (out_inexact)
);

// File: tb/tb_int2f_conv.sv
module tb_int2f_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_int = 64'd0;
    logic        out_valid;
    logic [31:0] out_float;
    logic        out_inexact;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [63:0] op;
        logic [31:0] res;
        logic        ix;
    } item_t;

    item_t sb[$];

    int2f_conv dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_int      (in_int),
        .out_valid   (out_valid),
        .out_float   (out_float),
        .out_inexact (out_inexact)
    );

    always #5 clk = ~clk;

    // single-step reference: round the magnitude straight to 24 bits
    function automatic void ref_conv(input logic [63:0] op,
                                     output logic [31:0] r, output logic ix);
        logic        s;
        logic [63:0] m, rem, half;
        logic [64:0] sig;
        int          p, sh;
        s = op[63];
        m = s ? (~op + 64'd1) : op;
        r = 32'd0; ix = 1'b0; p = 0;
        if (m != 64'd0) begin
            for (int i = 0; i < 64; i++) if (m[i]) p = i;
            if (p <= 23) begin
                sig = {1'b0, m} << (23 - p);
            end else begin
                sh   = p - 23;
                sig  = {1'b0, m >> sh};
                rem  = m & ((64'd1 << sh) - 64'd1);
                half = 64'd1 << (sh - 1);
                if (rem > half || (rem == half && sig[0])) sig = sig + 65'd1;
                ix = (rem != 64'd0);
                if (sig[24]) begin
                    sig = sig >> 1;
                    p   = p + 1;
                end
            end
            r = {s, 8'(127 + p), sig[22:0]};
        end
    endfunction

    task automatic send(input logic [63:0] op, input string tag);
        item_t it;
        it.tag = tag; it.op = op;
        ref_conv(op, it.res, it.ix);
        @(negedge clk);
        in_valid = 1'b1; in_int = op;
        sb.push_back(it);
    endtask

    task automatic send_exp(input logic [63:0] op, input logic [31:0] res,
                            input logic ix, input string tag);
        item_t it;
        it.tag = tag; it.op = op; it.res = res; it.ix = ix;
        @(negedge clk);
        in_valid = 1'b1; in_int = op;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            item_t it;
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1: strobe with nothing due, actual %h expected none", out_float);
            end else begin
                it = sb.pop_front();
                if (out_float !== it.res || out_inexact !== it.ix) begin
                    n_fail++;
                    $display("FAIL %s: op %h actual %h/%b expected %h/%b",
                             it.tag, it.op, out_float, out_inexact, it.res, it.ix);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R1: watchdog expired, actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_float !== 32'd0) begin
            n_fail++;
            $display("FAIL R1: reset state actual %b/%h expected 0/00000000", out_valid, out_float);
        end

        // R3: ties to even
        send_exp(64'h1000_0010_0000_0000, 32'h5D80_0000, 1'b1, "R3");
        send_exp(64'h1000_0030_0000_0000, 32'h5D80_0002, 1'b1, "R3");
        // R4: near-midpoint operands, back to back
        send_exp(64'h1000_0010_0000_0001, 32'h5D80_0001, 1'b1, "R4");
        send_exp(64'h1000_0010_0000_0080, 32'h5D80_0001, 1'b1, "R4");
        send_exp(64'h1000_002F_FFFF_FFFF, 32'h5D80_0001, 1'b1, "R4");
        for (int k = 1; k <= 128; k++)
            send_exp(64'h1000_0010_0000_0000 + 64'(k), 32'h5D80_0001, 1'b1, "R4");
        idle(2);
        // R5: mirror images
        send_exp(-64'h1000_0010_0000_0001, 32'hDD80_0001, 1'b1, "R5");
        send_exp(-64'h1000_0010_0000_0000, 32'hDD80_0000, 1'b1, "R5");
        send_exp(-64'd1, 32'hBF80_0000, 1'b0, "R5");
        // R6, R7, R8
        send_exp(64'd0, 32'h0000_0000, 1'b0, "R6");
        send_exp(64'h8000_0000_0000_0000, 32'hDF00_0000, 1'b0, "R7");
        send_exp(64'h0000_0000_01FF_FFFF, 32'h4C00_0000, 1'b1, "R8");
        send_exp(64'h7FFF_FFFF_FFFF_FFFF, 32'h5F00_0000, 1'b1, "R8");
        send_exp(64'd1, 32'h3F80_0000, 1'b0, "R8");
        // R9: exactness boundary
        send_exp(64'h0000_0000_00FF_FFFF, 32'h4B7F_FFFF, 1'b0, "R9");
        send_exp(64'h0000_0000_0100_0001, 32'h4B80_0000, 1'b1, "R9");
        send_exp(64'h0020_0000_0000_0000, 32'h5A00_0000, 1'b0, "R9");
        idle(1);

        // R2: random operands of varied magnitude, with gaps
        for (int n = 0; n < 3000; n++) begin
            v = {$urandom(), $urandom()} >> ($urandom() % 64);
            if ($urandom() % 2 == 1) v = ~v + 64'd1;
            send(v, "R2");
            if ($urandom() % 7 == 0) idle(1 + $urandom() % 3);
        end
        // R4: midpoint-targeted operands at random positions
        for (int n = 0; n < 3000; n++) begin
            int          p;
            logic [63:0] base;
            p    = 25 + ($urandom() % 38);
            base = ({40'd1, 24'($urandom())} | 64'h0100_0000) << (p - 24);
            base = base & ~((64'd1 << (p - 23)) - 64'd1);
            v    = base + (64'd1 << (p - 24)) + 64'($signed(($urandom() % 513) - 256));
            if ($urandom() % 2 == 1) v = ~v + 64'd1;
            send(v, "R4");
        end
        idle(4);

        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1: results missing, actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule